// File: doc/BRIEF.md
# Dual-Mode Output Compare Unit

This block watches a free-running timer count and raises a compare flag when the count equals a programmed compare value. It has two flags, A and B. In narrow mode each flag has its own comparator, and each comparator checks the low half of the count against its own compare byte. In wide mode the two compare bytes are joined into one full-width value, with B as the upper half. A single comparator then checks the whole count against that value and can only raise flag A.

Flags change only on timer ticks, which are cycles where the tick enable is high. An equality seen on one tick is held in a pending register. The flag is raised on the next tick. Each flag can request an interrupt when its enable is set. A flag is cleared either by a write-one strobe from software or by the acknowledge of its interrupt.

Top module: `dual_compare_unit`

## Requirements
- R1: In narrow mode (`wide_mode`=0), flag A is raised only when `count[7:0]` equals `cmp_a`. The upper byte of `count` has no effect.
- R2: An equality seen on a tick sets the flag on the next tick. It does not set the flag on the tick where the equality is seen.
- R3: In narrow mode, `count[7:0]`==`cmp_b` raises flag B independently of flag A. Both flags rise together when both compare bytes equal the count.
- R4: In wide mode (`wide_mode`=1), flag A is raised only when `count` equals {`cmp_b`,`cmp_a`}. Flag B is never raised in wide mode.
- R5: `irq_a`/`irq_b` is high exactly when its flag and its enable are both high. A one-cycle `ack_a`/`ack_b` clears the flag.
- R6: A one-cycle `clr_a`/`clr_b` strobe clears its flag.
- R7: When a flag is being set in the same cycle as a clear or acknowledge, the set wins.
- R8: Synchronous reset (`rst`=1) clears both flags and both pending match registers.
- R9: On cycles with `tick`=0, the pending match registers and the flag set path hold. An equality present only on a non-tick cycle is never recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer tick enable |
| count | input | 16 | Timer count value |
| cmp_a | input | 8 | Compare byte A (low half in wide mode) |
| cmp_b | input | 8 | Compare byte B (high half in wide mode) |
| wide_mode | input | 1 | 0: two narrow comparators, 1: one wide comparator |
| irq_en_a | input | 1 | Interrupt enable for flag A |
| irq_en_b | input | 1 | Interrupt enable for flag B |
| clr_a | input | 1 | Write-one clear strobe for flag A |
| clr_b | input | 1 | Write-one clear strobe for flag B |
| ack_a | input | 1 | Interrupt acknowledge for flag A |
| ack_b | input | 1 | Interrupt acknowledge for flag B |
| flag_a | output | 1 | Compare flag A |
| flag_b | output | 1 | Compare flag B |
| irq_a | output | 1 | Interrupt request A |
| irq_b | output | 1 | Interrupt request B |

## Verification
The assertions assume that clear and acknowledge strobes are single-cycle pulses. They also assume that `wide_mode` is stable across the tick where an equality is registered, so the pending B register is empty in wide mode. The stimulus changes the mode and the compare bytes only on non-tick cycles. It follows each scenario with a flushing tick at a count that does not match, then strobes both clears. No pending equality from one mode therefore carries into the next scenario.

// File: rtl/dcu_pkg.sv
package dcu_pkg;
  typedef enum logic {
    CMP_NARROW = 1'b0,
    CMP_WIDE   = 1'b1
  } cmp_mode_e;

  localparam int unsigned NUM_LANES = 2;
  localparam int unsigned LANE_A    = 0;
  localparam int unsigned LANE_B    = 1;
endpackage

// File: rtl/dcu_match.sv
module dcu_match
  import dcu_pkg::*;
#(
  parameter int unsigned WIDE_W = 16,
  localparam int unsigned HALF_W = WIDE_W / 2
) (
  input  logic [WIDE_W-1:0] count,
  input  logic [HALF_W-1:0] cmp_a,
  input  logic [HALF_W-1:0] cmp_b,
  input  cmp_mode_e         mode,
  output logic [NUM_LANES-1:0] hit
);
  logic [HALF_W-1:0] low_half;
  logic              wide_eq;

  assign low_half = count[HALF_W-1:0];
  assign wide_eq  = (count == {cmp_b, cmp_a});

  always_comb begin
    if (mode == CMP_WIDE) begin
      hit[LANE_A] = wide_eq;
      hit[LANE_B] = 1'b0;
    end else begin
      hit[LANE_A] = (low_half == cmp_a);
      hit[LANE_B] = (low_half == cmp_b);
    end
  end
endmodule

// File: rtl/dcu_flag.sv
module dcu_flag (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hit,
  input  logic clr,
  input  logic ack,
  input  logic irq_en,
  output logic pend,
  output logic flag,
  output logic irq
);
  logic set_now;

  assign set_now = tick & pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (tick) pend <= hit;
      if (set_now)          flag <= 1'b1;
      else if (clr || ack)  flag <= 1'b0;
    end
  end

  assign irq = flag & irq_en;

  // R2: a pending equality on a tick raises the flag next cycle
  p_set_next_tick_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && pend) |=> flag);
  // R9: the flag only rises from a pending equality on a tick
  p_rise_from_tick_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> ($past(tick) && $past(pend)));
  // R9: pending holds between ticks
  p_pend_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(pend));
  // R6 / R5: clear or acknowledge without a set empties the flag
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    ((clr || ack) && !(tick && pend)) |=> !flag);
  // R8: reset empties flag and pending state
  p_reset_r8: assert property (@(posedge clk)
    rst |=> (!flag && !pend));
endmodule

// File: rtl/dual_compare_unit.sv
module dual_compare_unit
  import dcu_pkg::*;
#(
  parameter int unsigned WIDE_W = 16,
  localparam int unsigned HALF_W = WIDE_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [WIDE_W-1:0] count,
  input  logic [HALF_W-1:0] cmp_a,
  input  logic [HALF_W-1:0] cmp_b,
  input  logic              wide_mode,
  input  logic              irq_en_a,
  input  logic              irq_en_b,
  input  logic              clr_a,
  input  logic              clr_b,
  input  logic              ack_a,
  input  logic              ack_b,
  output logic              flag_a,
  output logic              flag_b,
  output logic              irq_a,
  output logic              irq_b
);
  cmp_mode_e            mode;
  logic [NUM_LANES-1:0] hit;
  logic [NUM_LANES-1:0] clr_v, ack_v, en_v;
  logic [NUM_LANES-1:0] pend_v, flag_v, irq_v;

  assign mode  = wide_mode ? CMP_WIDE : CMP_NARROW;
  assign clr_v = {clr_b, clr_a};
  assign ack_v = {ack_b, ack_a};
  assign en_v  = {irq_en_b, irq_en_a};

  dcu_match #(.WIDE_W(WIDE_W)) u_match (
    .count (count),
    .cmp_a (cmp_a),
    .cmp_b (cmp_b),
    .mode  (mode),
    .hit   (hit)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    dcu_flag u_flag (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .hit    (hit[g]),
      .clr    (clr_v[g]),
      .ack    (ack_v[g]),
      .irq_en (en_v[g]),
      .pend   (pend_v[g]),
      .flag   (flag_v[g]),
      .irq    (irq_v[g])
    );
  end

  assign flag_a = flag_v[LANE_A];
  assign flag_b = flag_v[LANE_B];
  assign irq_a  = irq_v[LANE_A];
  assign irq_b  = irq_v[LANE_B];

  // R4: in wide mode nothing is ever recorded for lane B
  p_b_idle_wide_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && wide_mode) |=> !pend_v[LANE_B]);
  // R7: a set on a tick wins over a same-cycle clear
  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (tick && pend_v[LANE_A] && (clr_a || ack_a)) |=> flag_a);
endmodule

// File: tb/tb_dual_compare_unit.sv
module tb_dual_compare_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [15:0] count = 16'h0;
  logic [7:0]  cmp_a = 8'h0, cmp_b = 8'h0;
  logic        wide_mode = 1'b0;
  logic        irq_en_a = 1'b0, irq_en_b = 1'b0;
  logic        clr_a = 1'b0, clr_b = 1'b0, ack_a = 1'b0, ack_b = 1'b0;
  logic        flag_a, flag_b, irq_a, irq_b;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_compare_unit dut (
    .clk(clk), .rst(rst), .tick(tick), .count(count), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .wide_mode(wide_mode), .irq_en_a(irq_en_a), .irq_en_b(irq_en_b),
    .clr_a(clr_a), .clr_b(clr_b), .ack_a(ack_a), .ack_b(ack_b),
    .flag_a(flag_a), .flag_b(flag_b), .irq_a(irq_a), .irq_b(irq_b)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic [15:0] c);
    tick = t; count = c;
    @(posedge clk); #1;
    clr_a = 0; clr_b = 0; ack_a = 0; ack_b = 0; tick = 0;
  endtask

  task automatic flush();
    cyc(1, 16'hFFFF);
    clr_a = 1; clr_b = 1;
    cyc(0, 16'hFFFF);
  endtask

  task automatic t_reset();
    chk("R8", "flag_a after reset", flag_a, 0);
    chk("R8", "flag_b after reset", flag_b, 0);
    chk("R8", "irq_a after reset", irq_a, 0);
  endtask

  task automatic t_narrow_a();
    wide_mode = 0; cmp_a = 8'h20; cmp_b = 8'h77;
    cyc(1, 16'h5A20);
    chk("R2", "flag_a on matching tick", flag_a, 0);
    cyc(1, 16'h5A21);
    chk("R1", "flag_a next tick, upper byte ignored", flag_a, 1);
    chk("R3", "flag_b untouched by A match", flag_b, 0);
    clr_a = 1; cyc(0, 16'h5A21);
    chk("R6", "flag_a after clear strobe", flag_a, 0);
    flush();
  endtask

  task automatic t_narrow_b_and_both();
    wide_mode = 0; cmp_a = 8'h10; cmp_b = 8'h44;
    cyc(1, 16'h0144); cyc(1, 16'h0145);
    chk("R3", "flag_b after B match", flag_b, 1);
    chk("R3", "flag_a stays low on B match", flag_a, 0);
    flush();
    cmp_a = 8'h3C; cmp_b = 8'h3C;
    cyc(1, 16'h993C); cyc(1, 16'h0000);
    chk("R3", "flag_a on shared match", flag_a, 1);
    chk("R3", "flag_b on shared match", flag_b, 1);
    flush();
  endtask

  task automatic t_tick_gating();
    wide_mode = 0; cmp_a = 8'h05;
    cyc(1, 16'h0005);
    cyc(0, 16'h0006); cyc(0, 16'h0007); cyc(0, 16'h0008);
    chk("R9", "flag_a held low between ticks", flag_a, 0);
    cyc(1, 16'h0009);
    chk("R9", "flag_a set on next tick after gap", flag_a, 1);
    flush();
    cyc(0, 16'h0005);
    cyc(1, 16'h0006); cyc(1, 16'h0007);
    chk("R9", "match on non-tick cycle not recorded", flag_a, 0);
    flush();
  endtask

  task automatic t_wide();
    wide_mode = 1; cmp_a = 8'h34; cmp_b = 8'h12;
    cyc(0, 16'h0000);
    cyc(1, 16'h0034); cyc(1, 16'h0035);
    chk("R4", "low-byte-only match in wide mode", flag_a, 0);
    cyc(1, 16'h0012); cyc(1, 16'h0013);
    chk("R4", "flag_b never set in wide mode", flag_b, 0);
    cyc(1, 16'h1234);
    chk("R2", "wide flag_a on matching tick", flag_a, 0);
    cyc(1, 16'h1235);
    chk("R4", "flag_a on full-width match", flag_a, 1);
    chk("R4", "flag_b on full-width match", flag_b, 0);
    flush();
    wide_mode = 0;
    cyc(0, 16'hFFFF);
  endtask

  task automatic t_irq();
    wide_mode = 0; cmp_a = 8'h50; cmp_b = 8'h60; irq_en_a = 1; irq_en_b = 0;
    cyc(1, 16'h0050); cyc(1, 16'h0060); cyc(1, 16'h0000);
    chk("R5", "irq_a with flag and enable", irq_a, 1);
    chk("R5", "irq_b with flag but disabled", irq_b, 0);
    ack_a = 1; cyc(0, 16'h0000);
    chk("R5", "flag_a after ack", flag_a, 0);
    chk("R5", "irq_a after ack", irq_a, 0);
    irq_en_b = 1; #1;
    chk("R5", "irq_b after enable", irq_b, 1);
    ack_b = 1; cyc(0, 16'h0000);
    chk("R5", "flag_b after ack", flag_b, 0);
    irq_en_a = 0; irq_en_b = 0;
    flush();
  endtask

  task automatic t_priority();
    wide_mode = 0; cmp_a = 8'h81;
    cyc(1, 16'h0081);
    clr_a = 1; cyc(1, 16'h0000);
    chk("R7", "set wins over clear", flag_a, 1);
    flush();
    cyc(1, 16'h0081);
    ack_a = 1; cyc(1, 16'h0000);
    chk("R7", "set wins over ack", flag_a, 1);
    flush();
  endtask

  task automatic t_mid_reset();
    cmp_a = 8'h22; cmp_b = 8'h22;
    cyc(1, 16'h0022); cyc(1, 16'h0022);
    chk("R8", "flag_a set before reset", flag_a, 1);
    rst = 1; cyc(0, 16'h0000); rst = 0;
    chk("R8", "flag_a cleared by reset", flag_a, 0);
    chk("R8", "flag_b cleared by reset", flag_b, 0);
    cyc(1, 16'h0000);
    chk("R8", "pending cleared by reset", flag_a, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_narrow_a();
    t_narrow_b_and_both();
    t_tick_gating();
    t_wide();
    t_irq();
    t_priority();
    t_mid_reset();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule